// File: doc/BRIEF.md
# DMA Request/Acknowledge Handshake Controller

This block sits between a peripheral data FIFO and an external DMA master. Software arms it through a small byte-wide register file. It then raises a request pin, counts every word that the master acknowledges, and lowers the request when the transfer is over. A transfer ends when a down-counter reaches zero, or when software writes a stop command. Software reads a running bit and a sticky completion flag that also drives an interrupt line. Two live monitor bits show the request and acknowledge pin levels.

Each pin's polarity is configurable, and so is the pin-enable output that drives the external tri-state buffers. A stop command only drops the request. It does not halt the master. Software must therefore stop the master first and issue stop afterwards.

The handshake runs as a three-state machine:

- **IDLE**: nothing is running.
- **REQ**: the request is asserted and the block waits for an acknowledge edge.
- **HOLD**: used in single-word mode only. The request is withdrawn and the block waits for the acknowledge to go inactive.

The transitions are:

- **go** (IDLE→REQ).
- **go-empty** (IDLE→IDLE): a go in count-down mode with a zero count completes at once.
- **stop** (REQ/HOLD→IDLE).
- **word-last** (REQ→IDLE): the count-down reaches zero.
- **word-single** (REQ→HOLD).
- **word-multi** (REQ→REQ).
- **release** (HOLD→REQ): the acknowledge goes inactive.

Top module: `dmah_port`

## Requirements
- R1: Writing 1 to CTRL (address 0) bit0 while idle sets running (CTRL read bit0) and asserts the request at the next clock edge. A go written while running has no effect.
- R2: Writing 1 to CTRL bit1 while running returns the block to idle at the next edge, deasserts the request and sets the done flag. When go and stop are written together while idle, nothing starts and done is not set.
- R3: The acknowledge pin passes through two synchronising flops. One word is counted per synchronised active edge. In single-word mode the request drops at the third rising edge after the pin changes.
- R4: Writing 1 to CTRL bit2 zeroes the 32-bit count, but only while not running. Writes to the count bytes are likewise ignored while running.
- R5: In CFG (address 2), bit1 makes the request pin active-low, bit2 makes the acknowledge pin active-low, and bit3 makes both strobe pins active-low. All three reset to 0, which means active-high.
- R6: CFG bit0 enables the port and resets to 0. While it is 0, pin_oe is low and the acknowledge pin has no effect on the count or the state.
- R7: CFG bit4 = 1 selects count-down mode. Each counted word decrements the count. When the count reaches 0, running clears, the request drops and done is set. A go in this mode with a zero count sets done without starting.
- R8: CFG bit4 = 0 selects free-run mode. Each counted word increments the count, wrapping from all-ones to 0, and the transfer never ends by itself.
- R9: CFG bit5 = 1 selects single-word mode. The request drops after each counted word and returns once the synchronised acknowledge is inactive. With bit5 = 0 the request stays asserted across words.
- R10: STAT (address 1) bit0 is the done flag, mirrored on irq. It stays set until software writes 1 to it. Writing 0 leaves it set.
- R11: CTRL reads back running in bit0, the synchronised acknowledge pin level in bit6 and the request pin level in bit7. Addresses 4 to 7 hold count bytes 0 (LSB) to 3. Unused bits and address 3 read 0.
- R12: While the strobe pins are enabled and a word is acknowledged during a transfer, the write strobe is active when dir_wr = 1 and the read strobe is active when dir_wr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| dir_wr | input | 1 | Transfer direction, 1 = toward peripheral |
| ack_pin | input | 1 | Acknowledge pin from the DMA master |
| req_pin | output | 1 | Request pin to the DMA master |
| rd_pin | output | 1 | Read strobe pin |
| wr_pin | output | 1 | Write strobe pin |
| pin_oe | output | 1 | Enable for the external pin buffers |
| irq | output | 1 | Completion interrupt (done flag) |

## Verification
Suppose the state machine sits in the wrong state. The request pin then shows the wrong level within one clock of the acknowledge edge that should have moved it. The running bit shows the same fault on the next register read.

A counter fault shows up in two ways:

- A miscount or a missed lock-out appears in the count bytes read right after each word.
- In count-down mode, the count reaching zero too early or too late drops the request and raises irq on the wrong word.

Polarity or enable faults appear at once on the idle pin levels.

// File: rtl/dmah_pkg.sv
`timescale 1ns/1ps
package dmah_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HOLD = 2'd2
    } dmah_state_e;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_CFG  = 2;
    localparam int CNT_BASE  = 4;

    localparam int CFG_W       = 6;
    localparam int CB_EN       = 0;
    localparam int CB_REQ_LOW  = 1;
    localparam int CB_ACK_LOW  = 2;
    localparam int CB_STRB_LOW = 3;
    localparam int CB_DOWN     = 4;
    localparam int CB_SINGLE   = 5;
endpackage

// File: rtl/dmah_ack_sync.sv
`timescale 1ns/1ps
module dmah_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic port_en,
    input  logic act_low,
    output logic pin_level,
    output logic ack_act,
    output logic ack_edge
);
    logic [STAGES-1:0] sync_q;
    logic              act_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '0;
            act_prev_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[STAGES-2:0], pin_raw};
            act_prev_q <= ack_act;
        end
    end

    assign pin_level = sync_q[STAGES-1];
    assign ack_act   = port_en & (pin_level ^ act_low);
    assign ack_edge  = ack_act & ~act_prev_q;
endmodule

// File: rtl/dmah_counter.sv
`timescale 1ns/1ps
module dmah_counter #(
    parameter  int CNT_W  = 32,
    localparam int NBYTES = CNT_W / 8,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [7:0]       ld_byte,
    input  logic             step,
    input  logic             down,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero,
    output logic             cnt_one
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (ld_en) begin
            cnt_q[ld_sel*8 +: 8] <= ld_byte;
        end else if (step) begin
            if (down) cnt_q <= cnt_q - 1'b1;
            else      cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_W'(1));

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && down && !clr && !ld_en |=> cnt_q == $past(cnt_q) - 1'b1); // R7
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !down && !clr && !ld_en |=> cnt_q == $past(cnt_q) + 1'b1); // R8
endmodule

// File: rtl/dmah_fsm.sv
`timescale 1ns/1ps
module dmah_fsm
    import dmah_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_cmd,
    input  logic stop_cmd,
    input  logic mode_down,
    input  logic mode_single,
    input  logic cnt_zero,
    input  logic cnt_one,
    input  logic ack_edge,
    input  logic ack_act,
    output logic running,
    output logic req,
    output logic step,
    output logic finish
);
    dmah_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go_cmd && !stop_cmd) begin
                    if (mode_down && cnt_zero) finish  = 1'b1;
                    else                       state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (stop_cmd) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end else if (ack_edge) begin
                    step = 1'b1;
                    if (mode_down && cnt_one) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else if (mode_single) begin
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (stop_cmd) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end else if (!ack_act) begin
                    state_d = ST_REQ;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running = (state_q != ST_IDLE);
        req     = (state_q == ST_REQ);
    end

    AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack_edge && mode_single && !stop_cmd |=> !req); // R9
    AST_MULTI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack_edge && !mode_single && !stop_cmd && !(mode_down && cnt_one) |=> req); // R9
endmodule

// File: rtl/dmah_port.sv
`timescale 1ns/1ps
module dmah_port
    import dmah_pkg::*;
#(
    parameter  int CNT_W       = 32,
    parameter  int SYNC_STAGES = 2,
    localparam int NBYTES      = CNT_W / 8,
    localparam int ADDR_W      = $clog2(CNT_BASE + NBYTES),
    localparam int SEL_W       = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              dir_wr,
    input  logic              ack_pin,
    output logic              req_pin,
    output logic              rd_pin,
    output logic              wr_pin,
    output logic              pin_oe,
    output logic              irq
);
    logic [CFG_W-1:0] cfg_q;
    logic             done_q;
    logic             wr_ctrl, wr_stat, wr_cfg, in_cnt;
    logic             go_cmd, stop_cmd, clr_cmd, ld_en;
    logic [SEL_W-1:0] byte_sel;
    logic             running, req, step, finish;
    logic             ack_level, ack_act, ack_edge;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero, cnt_one, strb_act;

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign wr_stat  = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));
    assign wr_cfg   = reg_wr && (reg_addr == ADDR_W'(ADDR_CFG));
    assign in_cnt   = (reg_addr >= ADDR_W'(CNT_BASE));
    assign byte_sel = SEL_W'(reg_addr - ADDR_W'(CNT_BASE));
    assign go_cmd   = wr_ctrl && reg_wdata[0];
    assign stop_cmd = wr_ctrl && reg_wdata[1];
    assign clr_cmd  = wr_ctrl && reg_wdata[2] && !running;
    assign ld_en    = reg_wr && in_cnt && !running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr_cfg) cfg_q <= reg_wdata[CFG_W-1:0];
            if (finish)                       done_q <= 1'b1;
            else if (wr_stat && reg_wdata[0]) done_q <= 1'b0;
        end
    end

    dmah_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(ack_pin),
        .port_en(cfg_q[CB_EN]), .act_low(cfg_q[CB_ACK_LOW]),
        .pin_level(ack_level), .ack_act(ack_act), .ack_edge(ack_edge)
    );

    dmah_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_cmd), .ld_en(ld_en),
        .ld_sel(byte_sel), .ld_byte(reg_wdata), .step(step),
        .down(cfg_q[CB_DOWN]), .cnt_q(cnt_q), .cnt_zero(cnt_zero), .cnt_one(cnt_one)
    );

    dmah_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_cmd(go_cmd), .stop_cmd(stop_cmd),
        .mode_down(cfg_q[CB_DOWN]), .mode_single(cfg_q[CB_SINGLE]),
        .cnt_zero(cnt_zero), .cnt_one(cnt_one), .ack_edge(ack_edge), .ack_act(ack_act),
        .running(running), .req(req), .step(step), .finish(finish)
    );

    assign strb_act = running && ack_act;
    assign req_pin  = req ^ cfg_q[CB_REQ_LOW];
    assign wr_pin   = (strb_act && dir_wr) ^ cfg_q[CB_STRB_LOW];
    assign rd_pin   = (strb_act && !dir_wr) ^ cfg_q[CB_STRB_LOW];
    assign pin_oe   = cfg_q[CB_EN];
    assign irq      = done_q;

    always_comb begin
        reg_rdata = '0;
        if (in_cnt) begin
            reg_rdata = cnt_q[byte_sel*8 +: 8];
        end else if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata = {req_pin, ack_level, 5'b0, running};
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata = {7'b0, done_q};
        end else if (reg_addr == ADDR_W'(ADDR_CFG)) begin
            reg_rdata = {{(8-CFG_W){1'b0}}, cfg_q};
        end
    end

    AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !running && go_cmd && !stop_cmd && !(cfg_q[CB_DOWN] && cnt_zero) |=> running && req); // R1
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        running && stop_cmd |=> !running && !req && done_q); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !(wr_stat && reg_wdata[0]) |=> done_q); // R10
    AST_PORT_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[CB_EN] && !reg_wr |=> $stable(cnt_q)); // R6
endmodule

// File: tb/dmah_port_tb.sv
`timescale 1ns/1ps
module dmah_port_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       dir_wr, ack_pin;
    logic       req_pin, rd_pin, wr_pin, pin_oe, irq;

    int n_chk = 0;
    int n_fail = 0;
    logic bq_req_low = 1'b0;
    logic bq_ack_low = 1'b0;
    logic bq_strb_low = 1'b0;

    always #2.5 clk = ~clk;

    dmah_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_wr(dir_wr),
        .ack_pin(ack_pin), .req_pin(req_pin), .rd_pin(rd_pin), .wr_pin(wr_pin),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_count(input logic [31:0] start, input logic down, input int k);
        return down ? start - 32'(k) : start + 32'(k);
    endfunction

    function automatic logic [7:0] cfg_byte(input logic en, input logic rl, input logic al,
                                            input logic sl, input logic down, input logic single);
        return {2'b00, single, down, sl, al, rl, en};
    endfunction

    function automatic logic req_act();
        return req_pin ^ bq_req_low;
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic rd_count(output logic [31:0] c);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd_reg(3'(4 + i), b);
            c[i*8 +: 8] = b;
        end
    endtask

    task automatic setup(input logic en, input logic rl, input logic al, input logic sl,
                         input logic down, input logic single, input logic [31:0] start);
        bq_req_low = rl; bq_ack_low = al; bq_strb_low = sl;
        ack_pin = al;
        wr_reg(3'd2, cfg_byte(en, rl, al, sl, down, single));
        repeat (3) @(negedge clk);
        wr_reg(3'd1, 8'h01);
        for (int i = 0; i < 4; i++) wr_reg(3'(4 + i), start[i*8 +: 8]);
    endtask

    task automatic wait_req();
        for (int i = 0; i < 20 && req_act() !== 1'b1; i++) @(negedge clk);
        check("R1 request seen by master", 32'(req_act()), 32'd1);
    endtask

    task automatic do_word(input int hold, input logic exp_mid, input logic chk_strb);
        wait_req();
        ack_pin = 1'b1 ^ bq_ack_low;
        repeat (4) @(negedge clk);
        #1 check("R9 request level during acknowledge", 32'(req_act()), 32'(exp_mid));
        if (chk_strb) begin
            check("R12 write strobe", 32'(wr_pin ^ bq_strb_low), 32'(dir_wr));
            check("R12 read strobe", 32'(rd_pin ^ bq_strb_low), 32'(!dir_wr));
        end
        repeat (hold - 4) @(negedge clk);
        ack_pin = bq_ack_low;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [31:0] c;
        void'($urandom(32'd4711));
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        dir_wr = 1'b1; ack_pin = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_reg(3'd0, d); check("R11 ctrl after reset", 32'(d), 32'h0);
        rd_reg(3'd1, d); check("R10 stat after reset", 32'(d), 32'h0);
        rd_reg(3'd2, d); check("R5 cfg after reset", 32'(d), 32'h0);
        rd_reg(3'd3, d); check("R11 reserved address", 32'(d), 32'h0);
        rd_count(c);     check("R4 count after reset", c, 32'h0);
        check("R6 pin_oe after reset", 32'(pin_oe), 32'd0);
        check("R10 irq after reset", 32'(irq), 32'd0);

        // R6: ack ignored while port disabled
        setup(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd10);
        wr_reg(3'd0, 8'h01);
        check("R6 pin_oe low when disabled", 32'(pin_oe), 32'd0);
        for (int i = 0; i < 3; i++) begin
            ack_pin = 1'b1; repeat (5) @(negedge clk);
            ack_pin = 1'b0; repeat (5) @(negedge clk);
        end
        rd_count(c); check("R6 count frozen while disabled", c, 32'd10);
        wr_reg(3'd0, 8'h02);

        // R1 R7: multi-word count-down of three words
        setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd3);
        check("R6 pin_oe high when enabled", 32'(pin_oe), 32'd1);
        wr_reg(3'd0, 8'h01);
        check("R1 request after go", 32'(req_act()), 32'd1);
        rd_reg(3'd0, d); check("R1 running after go", 32'(d[0]), 32'd1);
        check("R11 request monitor bit", 32'(d[7]), 32'd1);
        do_word(5, 1'b1, 1'b0);
        rd_count(c); check("R7 count after word 1", c, 32'd2);
        do_word(5, 1'b1, 1'b0);
        rd_count(c); check("R7 count after word 2", c, 32'd1);
        do_word(5, 1'b0, 1'b0);
        rd_count(c); check("R7 count at end", c, 32'd0);
        rd_reg(3'd0, d); check("R7 running clear at end", 32'(d[0]), 32'd0);
        check("R7 irq at end", 32'(irq), 32'd1);

        // R10: sticky done
        wr_reg(3'd1, 8'h00);
        check("R10 write 0 keeps done", 32'(irq), 32'd1);
        wr_reg(3'd1, 8'h01);
        check("R10 write 1 clears done", 32'(irq), 32'd0);

        // R3 R9: single-word timing
        setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'd2);
        wr_reg(3'd0, 8'h01);
        wait_req();
        reg_addr = 3'd0;
        ack_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 check("R3 request still high after two edges", 32'(req_act()), 32'd1);
        check("R11 ack monitor after sync", 32'(reg_rdata[6]), 32'd1);
        @(negedge clk);
        #1 check("R3 request low after third edge", 32'(req_act()), 32'd0);
        repeat (2) @(negedge clk);
        ack_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 request back after release", 32'(req_act()), 32'd1);
        rd_count(c); check("R3 one word counted", c, 32'd1);
        do_word(6, 1'b0, 1'b0);
        check("R7 single-word end irq", 32'(irq), 32'd1);

        // R8 R4 R1 R2: free-run wrap, locked clear, stop
        setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFE);
        wr_reg(3'd0, 8'h01);
        for (int i = 0; i < 3; i++) do_word(4, 1'b1, 1'b0);
        rd_count(c); check("R8 free-run wraps", c, 32'h0000_0001);
        wr_reg(3'd0, 8'h04);
        rd_count(c); check("R4 clear ignored while running", c, 32'h0000_0001);
        wr_reg(3'd4, 8'h55);
        rd_count(c); check("R4 byte write ignored while running", c, 32'h0000_0001);
        wr_reg(3'd0, 8'h01);
        rd_reg(3'd0, d); check("R1 go while running ignored", 32'(d[0]), 32'd1);
        check("R2 no done before stop", 32'(irq), 32'd0);
        wr_reg(3'd0, 8'h02);
        check("R2 request dropped by stop", 32'(req_act()), 32'd0);
        check("R2 done set by stop", 32'(irq), 32'd1);
        rd_reg(3'd0, d); check("R2 running clear after stop", 32'(d[0]), 32'd0);
        wr_reg(3'd0, 8'h04);
        rd_count(c); check("R4 clear when idle", c, 32'h0);

        // R5 R12: inverted polarities
        setup(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'd0);
        check("R5 idle request pin active-low", 32'(req_pin), 32'd1);
        check("R5 idle strobe pins active-low", 32'({rd_pin, wr_pin}), 32'd3);
        wr_reg(3'd0, 8'h01);
        check("R5 asserted request pin low", 32'(req_pin), 32'd0);
        dir_wr = 1'b1;
        do_word(6, 1'b1, 1'b1);
        rd_count(c); check("R5 active-low acknowledge counted", c, 32'd1);
        wr_reg(3'd0, 8'h02);

        // R7: go with zero count; R2: go+stop together while idle
        setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0);
        wr_reg(3'd0, 8'h01);
        rd_reg(3'd0, d); check("R7 zero count does not run", 32'(d[0]), 32'd0);
        check("R7 zero count sets done", 32'(irq), 32'd1);
        setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd5);
        wr_reg(3'd0, 8'h03);
        rd_reg(3'd0, d); check("R2 stop wins over go", 32'(d[0]), 32'd0);
        check("R2 no done from idle stop", 32'(irq), 32'd0);

        // constrained random transfers
        for (int it = 0; it < 12; it++) begin
            logic rl, al, sl, down, single, run_end;
            logic [31:0] start;
            int k;
            rl = 1'($urandom % 2); al = 1'($urandom % 2); sl = 1'($urandom % 2);
            down = 1'($urandom % 2); single = 1'($urandom % 2);
            k = 1 + int'($urandom % 4);
            start = down ? 32'(k) + 32'($urandom % 2) : $urandom;
            dir_wr = 1'($urandom % 2);
            setup(1'b1, rl, al, sl, down, single, start);
            wr_reg(3'd0, 8'h01);
            for (int j = 1; j <= k; j++) begin
                logic fin;
                fin = down && (start - 32'(j) == 32'd0);
                do_word(4 + int'($urandom % 4), !single && !fin, !fin);
            end
            run_end = down && (start == 32'(k));
            rd_count(c); check(down ? "R7 random count" : "R8 random count", c, exp_count(start, down, k));
            rd_reg(3'd0, d); check("R7 R8 random running", 32'(d[0]), 32'(!run_end));
            if (!run_end) wr_reg(3'd0, 8'h02);
            check("R2 R7 random done", 32'(irq), 32'd1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule